// File: doc/BRIEF.md
# Hybrid Rule-90/150 Cellular Automaton Pattern Generator

This block produces pseudo-random test patterns from a one-dimensional array of N single-bit cells. On every enabled clock each cell computes its next value from its own value and its two adjacent cells. Cell i uses rule 150 when its rule bit is 1: the new value is the XOR of the lower neighbour, itself and the upper neighbour. With a rule bit of 0 it uses rule 90: the new value is the XOR of the two neighbours only. The lower neighbour of cell 0 and the upper neighbour of cell N-1 do not exist and read as constant 0 (null boundary). A good rule vector gives a long period, and adjacent output bits are less correlated than those of a shift-based generator.

A load strobe writes a new seed and a new rule vector together. The rule vector is held in a register between loads, so the rule input only matters when the load strobe is high. An enable input allows stepping, and with enable low the state is held. The cell count, the reset seed and the reset rule vector are parameters. Their defaults (N=4, rule bits cell0..cell3 = 1,0,1,0, seed cell0..cell3 = 0,0,0,1) give a maximum-length sequence of period 15.

Top module: `ca_pattern_gen`

## Requirements
- R1: After reset, bit i of pattern_o equals bit i of SEED_INIT, and the latched rule vector equals RULE_INIT. With the defaults, pattern_o = 4'b1000 (only cell 3 set).
- R2: When load_i is high at a rising edge, pattern_o shows seed_i from the next cycle, and rule_i is latched as the new rule vector.
- R3: A cell whose latched rule bit is 0 (rule 90) steps to the XOR of cell i-1 and cell i+1.
- R4: A cell whose latched rule bit is 1 (rule 150) steps to the XOR of cell i-1, cell i and cell i+1.
- R5: Cell 0 takes 0 as its cell i-1 input, and cell N-1 takes 0 as its cell i+1 input.
- R6: With load_i low and en_i low, pattern_o does not change.
- R7: load_i has priority over en_i. A load with en_i high writes the seed and does not step.
- R8: Changes on rule_i while load_i is low have no effect on the stepping.
- R9: With the default parameters and no load, the state written as cells 0..3 steps from 0001 through 0010, 0111, 1111, 0011, 0101, 1000, 1100, 0110, 1101, 0100, 1010, 1011, 1001, 1110. It returns to 0001 on the 15th step.
- R10: An all-zero state remains all-zero while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Load strobe for seed and rule vector |
| en_i | input | 1 | Step enable |
| seed_i | input | N | Seed, bit i goes to cell i |
| rule_i | input | N | Rule vector, bit i = 1 selects rule 150 for cell i |
| pattern_o | output | N | Current cell states, bit i is cell i |

## Verification
The rule logic is linear, so a wrong cell rule, a wrong neighbour or a leaking boundary corrupts the first enabled step that involves the affected cell. Any difference then spreads by at most one cell per step, and the full sequence reaches every bit within N steps. A latched rule that drifts or a lost load shows on the pattern one cycle after the offending edge. The default 15-step walk checks the period and every intermediate state. The directed steps isolate each boundary cell under each rule.

// File: rtl/ca_gen_pkg.sv
// Package: shared types for the cellular automaton pattern generator.
// Assumes: one rule bit per cell, 1 = rule 150, 0 = rule 90.
package ca_gen_pkg;

    typedef enum logic {
        RULE_90  = 1'b0,
        RULE_150 = 1'b1
    } cell_rule_e;

endpackage

// File: rtl/ca_rule_store.sv
// Module: ca_rule_store
// Holds the per-cell rule vector. It is written only on the load strobe
// and reset to RULE_INIT.
// Assumes: synchronous active-low reset.
module ca_rule_store #(
    parameter int          N         = 4,
    parameter logic [N-1:0] RULE_INIT = 4'b0101
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [N-1:0] rule_i,
    output logic [N-1:0] rule_o
);

    // Latch the rule vector on load, keep it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rule_o <= RULE_INIT;
        else if (load_i) rule_o <= rule_i;
    end

endmodule

// File: rtl/ca_cell.sv
// Module: ca_cell
// One automaton cell: a single flop whose next value is picked by its
// local rule (90 or 150) from its two neighbours and itself.
// Assumes: the boundary zeros are supplied by the parent.
module ca_cell
    import ca_gen_pkg::*;
#(
    parameter bit RESET_VAL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       seed_i,
    input  logic       step_i,
    input  cell_rule_e rule_i,
    input  logic       lower_i,
    input  logic       upper_i,
    output logic       state_o
);

    logic next_val;

    // Compute the successor value from the selected local rule.
    always_comb begin
        if (rule_i == RULE_150) next_val = lower_i ^ state_o ^ upper_i;
        else                    next_val = lower_i ^ upper_i;
    end

    // Register: reset, then load before step, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      state_o <= RESET_VAL;
        else if (load_i) state_o <= seed_i;
        else if (step_i) state_o <= next_val;
    end

endmodule

// File: rtl/ca_pattern_gen.sv
// Module: ca_pattern_gen (top)
// N-cell hybrid rule-90/150 cellular automaton with null boundaries.
// It is used as a pseudo-random pattern source.
// Assumes: N >= 2. The load strobe has priority over the enable.
module ca_pattern_gen
    import ca_gen_pkg::*;
#(
    parameter int           N         = 4,
    parameter logic [N-1:0] SEED_INIT = 4'b1000,
    parameter logic [N-1:0] RULE_INIT = 4'b0101
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         en_i,
    input  logic [N-1:0] seed_i,
    input  logic [N-1:0] rule_i,
    output logic [N-1:0] pattern_o
);

    localparam int LAST = N - 1;

    logic [N-1:0] rule_q;
    logic [N-1:0] cells;
    logic [N-1:0] lower_n;
    logic [N-1:0] upper_n;

    ca_rule_store #(.N(N), .RULE_INIT(RULE_INIT)) u_rules (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .rule_i (rule_i),
        .rule_o (rule_q)
    );

    for (genvar i = 0; i < N; i++) begin : g_cell
        // Lower neighbour: the cell below, or constant zero at cell 0.
        if (i == 0) begin : g_lo_edge
            assign lower_n[i] = 1'b0;
        end else begin : g_lo_mid
            assign lower_n[i] = cells[i-1];
        end
        // Upper neighbour: the cell above, or constant zero at the last cell.
        if (i == LAST) begin : g_hi_edge
            assign upper_n[i] = 1'b0;
        end else begin : g_hi_mid
            assign upper_n[i] = cells[i+1];
        end

        ca_cell #(.RESET_VAL(SEED_INIT[i])) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load_i),
            .seed_i  (seed_i[i]),
            .step_i  (en_i),
            .rule_i  (cell_rule_e'(rule_q[i])),
            .lower_i (lower_n[i]),
            .upper_i (upper_n[i]),
            .state_o (cells[i])
        );
    end

    assign pattern_o = cells;

endmodule

// File: rtl/ca_pattern_gen_chk.sv
// Module: ca_pattern_gen_chk
// Checker bound to ca_pattern_gen. It recomputes one automaton step from
// the previous pattern and rule vector and checks load, hold and rule latching.
module ca_pattern_gen_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load_i,
    input logic         en_i,
    input logic [N-1:0] seed_i,
    input logic [N-1:0] rule_i,
    input logic [N-1:0] rule_q,
    input logic [N-1:0] pattern_o
);

    function automatic logic [N-1:0] step_of(input logic [N-1:0] p,
                                             input logic [N-1:0] r);
        logic [N-1:0] res;
        for (int i = 0; i < N; i++) begin
            logic lo;
            logic hi;
            lo = (i == 0)     ? 1'b0 : p[(i == 0) ? 0 : i-1];
            hi = (i == N - 1) ? 1'b0 : p[(i == N - 1) ? i : i+1];
            res[i] = lo ^ hi ^ (r[i] & p[i]);
        end
        return res;
    endfunction

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (pattern_o == $past(seed_i)) && (rule_q == $past(rule_i)));

    // Rule step with null boundary: R3, R4, R5
    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i) |=> pattern_o == step_of($past(pattern_o), $past(rule_q)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !load_i) |=> $stable(pattern_o));

    assert_rule_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(rule_q));

    assert_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && pattern_o == '0) |=> pattern_o == '0);

endmodule

bind ca_pattern_gen ca_pattern_gen_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .en_i      (en_i),
    .seed_i    (seed_i),
    .rule_i    (rule_i),
    .rule_q    (rule_q),
    .pattern_o (pattern_o)
);

// File: tb/sim_ca_pattern_gen.sv
`timescale 1ns/1ps
module sim_ca_pattern_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic       en_i = 1'b0;
    logic [3:0] seed_i = '0;
    logic [3:0] rule_i = '0;
    logic [3:0] pattern_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ca_pattern_gen u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .en_i(en_i),
        .seed_i(seed_i), .rule_i(rule_i), .pattern_o(pattern_o)
    );

    // R9 sequence written as cells 0..3, leftmost character = cell 0.
    localparam logic [3:0] SEQ [0:15] = '{
        4'b0001, 4'b0010, 4'b0111, 4'b1111, 4'b0011, 4'b0101, 4'b1000, 4'b1100,
        4'b0110, 4'b1101, 4'b0100, 4'b1010, 4'b1011, 4'b1001, 4'b1110, 4'b0001
    };

    function automatic logic [3:0] cells_to_bits(input logic [3:0] s);
        return {s[0], s[1], s[2], s[3]};
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        checks++;
        if (pattern_o !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, pattern_o, exp);
        end
    endtask

    // One clock: inputs already driven at the negedge; sample at the next negedge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(input logic [3:0] s, input logic [3:0] r, input logic e);
        load_i = 1'b1; en_i = e; seed_i = s; rule_i = r;
        tick();
        load_i = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        check("R1 reset seed", 4'b1000);
        // R1: reset rule vector 0101 is shown by the default walk below.

        // R9 table walk (also exercises R3, R4, R5 on the default rules).
        en_i = 1'b1;
        for (int k = 1; k < 16; k++) begin
            tick();
            check($sformatf("R9 step %0d", k), cells_to_bits(SEQ[k]));
        end

        // R6: hold with enable low.
        en_i = 1'b0;
        tick(); tick(); tick();
        check("R6 hold", cells_to_bits(SEQ[15]));

        // R2: load with enable low.
        do_load(4'b0001, 4'b0000, 1'b0);
        check("R2 load seed", 4'b0001);

        // R3 + R5: all rule 90, cell 0 alone set.
        en_i = 1'b1;
        tick();
        check("R3 rule90 step1", 4'b0010);
        tick();
        check("R3 rule90 step2", 4'b0101);

        // R5: upper boundary under rule 90.
        do_load(4'b1000, 4'b0000, 1'b0);
        en_i = 1'b1;
        tick();
        check("R5 upper edge rule90", 4'b0100);

        // R4 + R5: all rule 150 at both edges.
        do_load(4'b0001, 4'b1111, 1'b0);
        en_i = 1'b1;
        tick();
        check("R4 rule150 lower edge", 4'b0011);
        do_load(4'b1000, 4'b1111, 1'b0);
        en_i = 1'b1;
        tick();
        check("R4 rule150 upper edge", 4'b1100);

        // R8: rule input changed without load must not matter.
        do_load(4'b0001, 4'b1111, 1'b0);
        rule_i = 4'b0000; en_i = 1'b1;
        tick();
        check("R8 rule input ignored", 4'b0011);

        // R7: load wins over enable.
        do_load(4'b0110, 4'b0101, 1'b1);
        check("R7 load priority", 4'b0110);

        // R10: zero state stays zero.
        do_load(4'b0000, 4'b0101, 1'b0);
        en_i = 1'b1;
        tick(); tick(); tick();
        check("R10 zero stays", 4'b0000);

        // R1: reset in mid-run restores seed and rule; one default step follows.
        do_load(4'b1011, 4'b0000, 1'b0);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        check("R1 re-reset seed", 4'b1000);
        en_i = 1'b1;
        tick();
        check("R1 reset rule vector", cells_to_bits(SEQ[1]));

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule